// File: doc/BRIEF.md
# AC-link Sample Word Packer

This block sits between the DMA-side data FIFOs of an AC-link controller and its slot serializer. On the transmit side it splits each 32-bit memory word into two 16-bit samples and hands them to the serializer one request at a time. It pops a word from the transmit FIFO only after both halves have gone out. On the receive side it collects 16-bit samples taken from captured 20-bit slots and builds 32-bit words for the receive FIFO.

Two word layouts are supported. Paired layout covers stereo streams (left then right) and single-channel streams (two time-consecutive samples); both put the earlier sample in the lower-addressed halfword. Microphone layout puts each sample alone in the earlier halfword and fills the other halfword with zeros. A byte-order input selects where the lower-addressed halfword sits: bits [15:0] for little-endian, bits [31:16] for big-endian. Starvation on transmit and congestion on receive each set a sticky flag.

Top module: `aclink_sample_packer`

## Requirements
- R1: A transmitted slot carries its sample in bits [19:4] with bits [3:0] driven zero. A received slot's sample is taken from bits [19:4], and its bits [3:0] do not affect the assembled word.
- R2: Each accepted transmit request puts the next sample on `tx_slot` one cycle later. From each FIFO word the lower-addressed halfword goes out first and the other second. The lower-addressed halfword is bits [15:0] when `big_endian`=0 and bits [31:16] when `big_endian`=1.
- R3: `tx_fifo_pop` is high during a request cycle only when that request takes the second halfword of the head word. The request that takes the first halfword does not pop.
- R4: If a request arrives for a first halfword while `tx_fifo_empty` is high, the block sends a zero sample and does not pop. It also sets `tx_underrun`, which then stays high until reset.
- R5: In paired layout (`rx_mic_mode`=0), two accepted samples form one word, with the earlier sample in the lower-addressed halfword. `rx_push` is high for exactly one cycle, the cycle after the second sample, with the word on `rx_word`. The first sample pushes nothing.
- R6: In microphone layout (`rx_mic_mode`=1), every accepted sample pushes a word one cycle later. The sample sits in the lower-addressed halfword and the other halfword is zero.
- R7: If `rx_fifo_full` is high in the cycle a word completes, the word is dropped and no push occurs. `rx_overrun` is set and stays high until reset, and the next sample starts a fresh word.
- R8: While `tx_en` is low, requests are ignored: no pop, no underrun, and `tx_slot` reads zero. The halfword position also returns to the first half, so the head word restarts from its first sample. While `rx_en` is low, samples are ignored and any half-built word is discarded.
- R9: After reset, `tx_slot`, `tx_fifo_pop`, `tx_underrun`, `rx_push`, `rx_word` and `rx_overrun` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | 1: lower-addressed halfword is bits [31:16] |
| tx_en | input | 1 | Transmit stream enable |
| tx_req | input | 1 | Serializer asks for the next sample |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no word |
| tx_fifo_data | input | 32 | Head word of the show-ahead transmit FIFO |
| tx_fifo_pop | output | 1 | Remove the head word at this edge |
| tx_slot | output | 20 | Slot field for the serializer |
| tx_underrun | output | 1 | Sticky transmit starvation flag |
| rx_en | input | 1 | Receive stream enable |
| rx_mic_mode | input | 1 | 1: microphone layout, 0: paired layout |
| rx_valid | input | 1 | A captured slot is present |
| rx_slot | input | 20 | Captured slot field |
| rx_fifo_full | input | 1 | Receive FIFO cannot take a word |
| rx_push | output | 1 | Write `rx_word` into the receive FIFO |
| rx_word | output | 32 | Assembled word |
| rx_overrun | output | 1 | Sticky receive drop flag |

## Verification
`tx_fifo_pop` is combinational in the request cycle. The bench reads it 1 ns after driving the request at a falling edge, before the capturing rising edge. `tx_slot`, `tx_underrun`, `rx_push`, `rx_word` and `rx_overrun` are registered one edge after the accepting cycle, so each stimulus is held for one cycle and these outputs are read at the next falling edge. The bench's transmit FIFO model pops on the same rising edge that the design sees, so the head word the bench expects always matches what the design is given.

// File: rtl/aclk_pack_pkg.sv
package aclk_pack_pkg;
   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } half_phase_t;
endpackage

// File: rtl/aclk_tx_unpack.sv
module aclk_tx_unpack
   import aclk_pack_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int SLOT_W   = 20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  big_endian,
   input  logic                  en,
   input  logic                  req,
   input  logic                  fifo_empty,
   input  logic [2*SAMPLE_W-1:0] fifo_data,
   output logic                  fifo_pop,
   output logic [SLOT_W-1:0]     slot,
   output logic                  underrun
);
   localparam int WORD_W = 2 * SAMPLE_W;
   localparam int PAD_W  = SLOT_W - SAMPLE_W;

   half_phase_t         phase;
   logic [SAMPLE_W-1:0] sample_q;
   logic [SAMPLE_W-1:0] pick;
   logic                accept;
   logic                starve;
   logic                take_hi;

   assign accept   = en & req;
   assign starve   = accept & (phase == PH_FIRST) & fifo_empty;
   assign fifo_pop = accept & (phase == PH_SECOND);
   assign take_hi  = big_endian ^ (phase == PH_SECOND);
   assign pick     = take_hi ? fifo_data[WORD_W-1:SAMPLE_W] : fifo_data[SAMPLE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_FIRST;
         sample_q <= '0;
         underrun <= 1'b0;
      end else if (!en) begin
         phase    <= PH_FIRST;
         sample_q <= '0;
      end else if (accept) begin
         if (starve) begin
            sample_q <= '0;
            underrun <= 1'b1;
         end else begin
            sample_q <= pick;
            phase    <= (phase == PH_FIRST) ? PH_SECOND : PH_FIRST;
         end
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign slot = {sample_q, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign slot = sample_q;
      end
   endgenerate
endmodule

// File: rtl/aclk_rx_pack.sv
module aclk_rx_pack
   import aclk_pack_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int SLOT_W   = 20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  big_endian,
   input  logic                  en,
   input  logic                  mic_mode,
   input  logic                  valid,
   input  logic [SLOT_W-1:0]     slot_in,
   input  logic                  fifo_full,
   output logic                  push,
   output logic [2*SAMPLE_W-1:0] word,
   output logic                  overrun
);
   localparam int WORD_W = 2 * SAMPLE_W;

   function automatic logic [WORD_W-1:0] place(input logic [SAMPLE_W-1:0] early,
                                               input logic [SAMPLE_W-1:0] late,
                                               input logic be);
      return be ? {early, late} : {late, early};
   endfunction

   half_phase_t         phase;
   logic [SAMPLE_W-1:0] held;
   logic [SAMPLE_W-1:0] sample;
   logic [WORD_W-1:0]   new_word;
   logic                accept;
   logic                complete;

   assign sample   = slot_in[SLOT_W-1 -: SAMPLE_W];
   assign accept   = en & valid;
   assign complete = accept & (mic_mode | (phase == PH_SECOND));
   assign new_word = mic_mode ? place(sample, '0, big_endian)
                              : place(held, sample, big_endian);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_FIRST;
         held    <= '0;
         push    <= 1'b0;
         word    <= '0;
         overrun <= 1'b0;
      end else begin
         push <= 1'b0;
         if (!en) begin
            phase <= PH_FIRST;
            held  <= '0;
         end else if (accept) begin
            if (complete) begin
               phase <= PH_FIRST;
               if (fifo_full) begin
                  overrun <= 1'b1;
               end else begin
                  push <= 1'b1;
                  word <= new_word;
               end
            end else begin
               held  <= sample;
               phase <= PH_SECOND;
            end
         end
      end
   end
endmodule

// File: rtl/aclink_sample_packer.sv
module aclink_sample_packer #(
   parameter int SAMPLE_W = 16,
   parameter int SLOT_W   = 20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  big_endian,
   input  logic                  tx_en,
   input  logic                  tx_req,
   input  logic                  tx_fifo_empty,
   input  logic [2*SAMPLE_W-1:0] tx_fifo_data,
   output logic                  tx_fifo_pop,
   output logic [SLOT_W-1:0]     tx_slot,
   output logic                  tx_underrun,
   input  logic                  rx_en,
   input  logic                  rx_mic_mode,
   input  logic                  rx_valid,
   input  logic [SLOT_W-1:0]     rx_slot,
   input  logic                  rx_fifo_full,
   output logic                  rx_push,
   output logic [2*SAMPLE_W-1:0] rx_word,
   output logic                  rx_overrun
);
   generate
      if (SAMPLE_W < 1) begin : g_bad_sample
         $error("SAMPLE_W must be at least 1");
      end
      if (SLOT_W < SAMPLE_W) begin : g_bad_slot
         $error("SLOT_W must not be narrower than SAMPLE_W");
      end
   endgenerate

   aclk_tx_unpack #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .big_endian (big_endian),
      .en         (tx_en),
      .req        (tx_req),
      .fifo_empty (tx_fifo_empty),
      .fifo_data  (tx_fifo_data),
      .fifo_pop   (tx_fifo_pop),
      .slot       (tx_slot),
      .underrun   (tx_underrun)
   );

   aclk_rx_pack #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .big_endian (big_endian),
      .en         (rx_en),
      .mic_mode   (rx_mic_mode),
      .valid      (rx_valid),
      .slot_in    (rx_slot),
      .fifo_full  (rx_fifo_full),
      .push       (rx_push),
      .word       (rx_word),
      .overrun    (rx_overrun)
   );
endmodule

// File: rtl/aclink_sample_packer_chk.sv
module aclink_sample_packer_chk #(
   parameter int SAMPLE_W = 16,
   parameter int SLOT_W   = 20
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  big_endian,
   input logic                  tx_en,
   input logic                  tx_req,
   input logic                  tx_fifo_empty,
   input logic                  tx_fifo_pop,
   input logic [SLOT_W-1:0]     tx_slot,
   input logic                  tx_underrun,
   input logic                  rx_en,
   input logic                  rx_mic_mode,
   input logic                  rx_valid,
   input logic                  rx_fifo_full,
   input logic                  rx_push,
   input logic [2*SAMPLE_W-1:0] rx_word,
   input logic                  rx_overrun
);
   localparam int WORD_W = 2 * SAMPLE_W;
   localparam int PAD_W  = SLOT_W - SAMPLE_W;

   generate
      if (PAD_W > 0) begin : g_pad_chk
         p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
            tx_slot[PAD_W-1:0] == '0);
      end
   endgenerate

   p_pop_on_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fifo_pop |-> (tx_req && tx_en && !tx_fifo_empty));

   p_starve_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && tx_req && tx_fifo_empty) |=> tx_underrun);

   p_underrun_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun |=> tx_underrun);

   p_push_after_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> ($past(rx_valid) && $past(rx_en)));

   p_mic_zero_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && $past(rx_mic_mode)) |->
         ($past(big_endian) ? (rx_word[SAMPLE_W-1:0] == '0)
                            : (rx_word[WORD_W-1:SAMPLE_W] == '0)));

   p_no_push_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> !$past(rx_fifo_full));

   p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |=> rx_overrun);

   p_tx_idle_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> !tx_fifo_pop);

   p_tx_idle_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (tx_slot == '0));

   p_rx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_push);
endmodule

bind aclink_sample_packer aclink_sample_packer_chk #(
   .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .big_endian    (big_endian),
   .tx_en         (tx_en),
   .tx_req        (tx_req),
   .tx_fifo_empty (tx_fifo_empty),
   .tx_fifo_pop   (tx_fifo_pop),
   .tx_slot       (tx_slot),
   .tx_underrun   (tx_underrun),
   .rx_en         (rx_en),
   .rx_mic_mode   (rx_mic_mode),
   .rx_valid      (rx_valid),
   .rx_fifo_full  (rx_fifo_full),
   .rx_push       (rx_push),
   .rx_word       (rx_word),
   .rx_overrun    (rx_overrun)
);

// File: tb/aclink_sample_packer_tb.sv
`timescale 1ns/1ps
module aclink_sample_packer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        big_endian = 1'b0;
   logic        tx_en = 1'b0;
   logic        tx_req = 1'b0;
   logic        tx_fifo_empty;
   logic [31:0] tx_fifo_data;
   logic        tx_fifo_pop;
   logic [19:0] tx_slot;
   logic        tx_underrun;
   logic        rx_en = 1'b0;
   logic        rx_mic_mode = 1'b0;
   logic        rx_valid = 1'b0;
   logic [19:0] rx_slot = '0;
   logic        rx_fifo_full = 1'b0;
   logic        rx_push;
   logic [31:0] rx_word;
   logic        rx_overrun;

   int n_checks = 0;
   int n_fail = 0;

   logic [31:0] txq [0:15];
   int tx_wr = 0;
   int tx_rd = 0;

   always #5 clk = ~clk;

   assign tx_fifo_empty = (tx_rd == tx_wr);
   assign tx_fifo_data  = txq[tx_rd[3:0]];
   always @(posedge clk) if (tx_fifo_pop) tx_rd <= tx_rd + 1;

   aclink_sample_packer u_dut (
      .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
      .tx_en(tx_en), .tx_req(tx_req), .tx_fifo_empty(tx_fifo_empty),
      .tx_fifo_data(tx_fifo_data), .tx_fifo_pop(tx_fifo_pop),
      .tx_slot(tx_slot), .tx_underrun(tx_underrun),
      .rx_en(rx_en), .rx_mic_mode(rx_mic_mode), .rx_valid(rx_valid),
      .rx_slot(rx_slot), .rx_fifo_full(rx_fifo_full), .rx_push(rx_push),
      .rx_word(rx_word), .rx_overrun(rx_overrun)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tx_load(input logic [31:0] w);
      txq[tx_wr[3:0]] = w;
      tx_wr++;
   endtask

   task automatic tx_step(input logic [15:0] exp, input bit exp_pop, input string tag);
      @(negedge clk);
      tx_req = 1'b1;
      #1;
      check(tx_fifo_pop == exp_pop, {tag, " R3 pop"}, {31'd0, tx_fifo_pop}, {31'd0, exp_pop});
      @(negedge clk);
      tx_req = 1'b0;
      check(tx_slot == {exp, 4'h0}, {tag, " R2/R1 slot"}, {12'd0, tx_slot}, {12'd0, exp, 4'h0});
   endtask

   task automatic rx_step(input logic [15:0] s, input bit exp_push, input logic [31:0] exp_w, input string tag);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_slot  = {s, 4'hA};
      @(negedge clk);
      rx_valid = 1'b0;
      rx_slot  = '0;
      check(rx_push == exp_push, {tag, " push"}, {31'd0, rx_push}, {31'd0, exp_push});
      if (exp_push)
         check(rx_word == exp_w, {tag, " word R1"}, rx_word, exp_w);
   endtask

   task automatic t_reset;
      check(tx_slot == '0 && !tx_fifo_pop && !tx_underrun, "R9 tx reset", {12'd0, tx_slot}, 32'd0);
      check(!rx_push && rx_word == '0 && !rx_overrun, "R9 rx reset", rx_word, 32'd0);
   endtask

   task automatic t_tx_little;
      big_endian = 1'b0;
      tx_en = 1'b1;
      tx_load(32'h2222_1111);
      tx_load(32'h4444_3333);
      tx_step(16'h1111, 1'b0, "R2 le first");
      tx_step(16'h2222, 1'b1, "R2 le second");
      tx_step(16'h3333, 1'b0, "R2 le third");
      tx_step(16'h4444, 1'b1, "R2 le fourth");
   endtask

   task automatic t_tx_big;
      big_endian = 1'b1;
      tx_load(32'hAAAA_BBBB);
      tx_step(16'hAAAA, 1'b0, "R2 be first");
      tx_step(16'hBBBB, 1'b1, "R2 be second");
      big_endian = 1'b0;
   endtask

   task automatic t_tx_disable;
      tx_en = 1'b0;
      @(negedge clk);
      tx_req = 1'b1;
      #1;
      check(!tx_fifo_pop, "R8 idle empty no pop", {31'd0, tx_fifo_pop}, 32'd0);
      @(negedge clk);
      tx_req = 1'b0;
      check(!tx_underrun, "R8 idle no underrun", {31'd0, tx_underrun}, 32'd0);
      tx_en = 1'b1;
      tx_load(32'h7777_8888);
      tx_step(16'h8888, 1'b0, "R8 before drop");
      tx_en = 1'b0;
      @(negedge clk);
      tx_req = 1'b1;
      #1;
      check(!tx_fifo_pop, "R8 disabled no pop", {31'd0, tx_fifo_pop}, 32'd0);
      @(negedge clk);
      tx_req = 1'b0;
      check(tx_slot == '0, "R8 disabled slot zero", {12'd0, tx_slot}, 32'd0);
      tx_en = 1'b1;
      tx_step(16'h8888, 1'b0, "R8 restart first");
      tx_step(16'h7777, 1'b1, "R8 restart second");
   endtask

   task automatic t_tx_underrun;
      tx_step(16'h0000, 1'b0, "R4 starve");
      check(tx_underrun, "R4 underrun set", {31'd0, tx_underrun}, 32'd1);
      tx_load(32'h5555_6666);
      tx_step(16'h6666, 1'b0, "R4 resume first");
      tx_step(16'h5555, 1'b1, "R4 resume second");
      check(tx_underrun, "R4 underrun sticky", {31'd0, tx_underrun}, 32'd1);
   endtask

   task automatic t_rx_pair;
      rx_en = 1'b1;
      rx_mic_mode = 1'b0;
      big_endian = 1'b0;
      rx_step(16'h1234, 1'b0, 32'h0, "R5 le first");
      rx_step(16'h5678, 1'b1, 32'h5678_1234, "R5 le second");
      big_endian = 1'b1;
      rx_step(16'h1234, 1'b0, 32'h0, "R5 be first");
      rx_step(16'h5678, 1'b1, 32'h1234_5678, "R5 be second");
      big_endian = 1'b0;
   endtask

   task automatic t_rx_mic;
      rx_mic_mode = 1'b1;
      rx_step(16'h9ABC, 1'b1, 32'h0000_9ABC, "R6 le mic");
      big_endian = 1'b1;
      rx_step(16'h9ABC, 1'b1, 32'h9ABC_0000, "R6 be mic");
      big_endian = 1'b0;
      rx_mic_mode = 1'b0;
   endtask

   task automatic t_rx_disable;
      rx_step(16'h1111, 1'b0, 32'h0, "R8 rx half");
      rx_en = 1'b0;
      rx_step(16'h2222, 1'b0, 32'h0, "R8 rx ignored");
      rx_en = 1'b1;
      rx_step(16'h3333, 1'b0, 32'h0, "R8 rx fresh first");
      rx_step(16'h4444, 1'b1, 32'h4444_3333, "R8 rx fresh word");
   endtask

   task automatic t_rx_overrun;
      check(!rx_overrun, "R7 overrun clear", {31'd0, rx_overrun}, 32'd0);
      rx_step(16'hAAAA, 1'b0, 32'h0, "R7 first");
      rx_fifo_full = 1'b1;
      rx_step(16'hBBBB, 1'b0, 32'h0, "R7 dropped");
      rx_fifo_full = 1'b0;
      check(rx_overrun, "R7 overrun set", {31'd0, rx_overrun}, 32'd1);
      rx_step(16'hCCCC, 1'b0, 32'h0, "R7 restart first");
      rx_step(16'hDDDD, 1'b1, 32'hDDDD_CCCC, "R7 restart word");
      check(rx_overrun, "R7 overrun sticky", {31'd0, rx_overrun}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx_little();
      t_tx_big();
      t_tx_disable();
      t_tx_underrun();
      t_rx_pair();
      t_rx_mic();
      t_rx_disable();
      t_rx_overrun();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule